// File: doc/BRIEF.md
# Host-to-Controller Doorbell Mailbox

This block is a small register window that lets a host processor hand commands to an embedded controller and collect the results. The host fills a four-word outbound buffer, then writes one command word. That write marks the mailbox busy and rings a one-cycle doorbell toward the controller. The controller sees the latched command code, the sub-command id, the payload size and the outbound buffer contents.

The controller can load response words into an inbound buffer. It finishes with a one-cycle done pulse that carries an error flag, an error code and an initiator id. The host then either polls the busy bit in the status word or, if the command asked for it, receives a one-cycle completion pulse. Each command picks one of these two ways to learn of completion through its own interrupt-request bit. Reads are combinational from the address. The inbound buffer can be read as whole words or as single bytes.

Top module: `mbx_top`

## Requirements
- R1: After reset the status word (address 0x04) reads zero, and the doorbell and host completion outputs are low.
- R2: A host write to address 0x00 while idle sets busy (status bit 0). In the next cycle it pulses `ctlDoorbell` for exactly one cycle and presents the command fields to the controller: code from bits 7:0, interrupt request from bit 8, sub-command id from bits 15:12, payload size from bits 23:16.
- R3: A write to address 0x00 while busy is ignored: no doorbell pulse, and the presented command fields keep their values.
- R4: A `ctlDone` pulse while busy clears busy and latches the error flag into status bit 1, the initiator id into bits 15:8 and the error code into bits 23:16. Status bits 7:4 show the sub-command id of the accepted command.
- R5: When the finished command had its interrupt-request bit set, `hostIrq` is high for exactly the one cycle after the accepted done pulse.
- R6: When the finished command had its interrupt-request bit clear, `hostIrq` stays low.
- R7: A host write to address 0x80 + 4k (k = 0..3) stores the word in outbound word k, visible on `ctlOutBuf` bits 32k+31:32k.
- R8: The controller loads inbound word k through `ctlRspWe`/`ctlRspIdx`. A host word read at 0x90 + 4k returns it. With `hostRdByte` set, a read at 0x90 + n (n = 0..15) returns byte n%4 of word n/4 in bits 7:0, with the upper bits zero.
- R9: A `ctlDone` pulse while idle is ignored: status is unchanged and `hostIrq` stays low.
- R10: The write-only addresses (0x00 and the outbound buffer) and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 8 | Host byte address |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 32 | Host write data |
| hostRdByte | input | 1 | Host read returns one byte of the inbound buffer |
| hostRdData | output | 32 | Host read data (combinational) |
| hostIrq | output | 1 | One-cycle completion pulse to the host |
| ctlDoorbell | output | 1 | One-cycle new-command pulse to the controller |
| ctlCmdCode | output | 8 | Latched command code |
| ctlIoc | output | 1 | Latched interrupt-request bit |
| ctlSubId | output | 4 | Latched sub-command id |
| ctlSize | output | 8 | Latched payload size in bytes |
| ctlOutBuf | output | 128 | Outbound buffer contents, word k at bits 32k+31:32k |
| ctlRspWe | input | 1 | Inbound buffer word write enable |
| ctlRspIdx | input | 2 | Inbound buffer word index |
| ctlRspData | input | 32 | Inbound buffer word data |
| ctlDone | input | 1 | Command finished pulse |
| ctlErr | input | 1 | Error flag sampled with done |
| ctlErrCode | input | 8 | Error code sampled with done |
| ctlInitId | input | 8 | Initiator id sampled with done |

## Verification
The hardest situation to reach is a second command write that lands while the first is still in flight, because a well-behaved host never does it. The bench forces it in every sweep step. It writes a different command word between launch and done, and then checks that no doorbell appears and that the presented fields still hold the first command. A done pulse with no command pending is also driven, both after reset and between commands, to show that it leaves status and the interrupt line alone.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic launch;  // command accepted this cycle
    logic finish;  // completion accepted this cycle
  } mbxStrobe_t;

  localparam logic [7:0] CMD_ADDR  = 8'h00;
  localparam logic [7:0] STAT_ADDR = 8'h04;
  localparam logic [7:0] OUT_BASE  = 8'h80;
  localparam logic [7:0] IN_BASE   = 8'h90;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic       iocBit,
  input  logic       ctlDone,
  output mbxStrobe_t strb,
  output logic       busy,
  output logic       doorbell,
  output logic       hostIrq
);
  logic iocQ;

  always_comb begin
    strb.launch = cmdWr & ~busy;
    strb.finish = ctlDone & busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      doorbell <= 1'b0;
      hostIrq  <= 1'b0;
      iocQ     <= 1'b0;
    end else begin
      doorbell <= strb.launch;
      hostIrq  <= strb.finish & iocQ;
      if (strb.launch) begin
        busy <= 1'b1;
        iocQ <= iocBit;
      end else if (strb.finish) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbx_data.sv
module mbx_data
  import mbx_pkg::*;
#(
  parameter int BUF_WORDS = 4,
  parameter int DW        = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  mbxStrobe_t                strb,
  input  logic                      busy,
  input  logic [7:0]                hostAddr,
  input  logic                      hostWrEn,
  input  logic [DW-1:0]             hostWrData,
  input  logic                      hostRdByte,
  output logic [DW-1:0]             hostRdData,
  output logic                      cmdWr,
  output logic                      iocBit,
  output logic [7:0]                cmdCode,
  output logic                      cmdIoc,
  output logic [3:0]                subId,
  output logic [7:0]                paySize,
  output logic [BUF_WORDS*DW-1:0]   outFlat,
  input  logic                      rspWe,
  input  logic [$clog2(BUF_WORDS)-1:0] rspIdx,
  input  logic [DW-1:0]             rspData,
  input  logic                      doneErr,
  input  logic [7:0]                doneCode,
  input  logic [7:0]                doneInit
);
  localparam int IDX_W     = $clog2(BUF_WORDS);
  localparam int BYTES     = DW / 8;
  localparam int BUF_BYTES = BUF_WORDS * BYTES;
  localparam int BSEL_W    = $clog2(BYTES);

  logic [DW-1:0] outMem [BUF_WORDS];
  logic [DW-1:0] inMem  [BUF_WORDS];
  logic          errQ;
  logic [7:0]    errCodeQ, initQ;

  logic inOut, inIn;
  logic [IDX_W-1:0]  wIdx;
  logic [BSEL_W-1:0] bSel;
  logic [DW-1:0]     inWord;

  always_comb begin
    inOut  = (hostAddr >= OUT_BASE) && (hostAddr < OUT_BASE + 8'(BUF_BYTES));
    inIn   = (hostAddr >= IN_BASE)  && (hostAddr < IN_BASE  + 8'(BUF_BYTES));
    wIdx   = hostAddr[BSEL_W +: IDX_W];
    bSel   = hostAddr[BSEL_W-1:0];
    cmdWr  = hostWrEn && (hostAddr == CMD_ADDR);
    iocBit = hostWrData[8];
    inWord = inMem[wIdx];
    hostRdData = '0;
    if (hostAddr == STAT_ADDR)
      hostRdData = DW'({8'h00, errCodeQ, initQ, subId, 2'b00, errQ, busy});
    else if (inIn)
      hostRdData = hostRdByte ? DW'(inWord[8*bSel +: 8]) : inWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdCode  <= '0;
      cmdIoc   <= 1'b0;
      subId    <= '0;
      paySize  <= '0;
      errQ     <= 1'b0;
      errCodeQ <= '0;
      initQ    <= '0;
    end else begin
      if (strb.launch) begin
        cmdCode <= hostWrData[7:0];
        cmdIoc  <= hostWrData[8];
        subId   <= hostWrData[15:12];
        paySize <= hostWrData[23:16];
      end
      if (strb.finish) begin
        errQ     <= doneErr;
        errCodeQ <= doneCode;
        initQ    <= doneInit;
      end
    end
  end

  for (genvar k = 0; k < BUF_WORDS; k++) begin : gBuf
    always_ff @(posedge clk) begin
      if (!rstN) begin
        outMem[k] <= '0;
        inMem[k]  <= '0;
      end else begin
        if (hostWrEn && inOut && wIdx == IDX_W'(k)) outMem[k] <= hostWrData;
        if (rspWe && rspIdx == IDX_W'(k))           inMem[k]  <= rspData;
      end
    end
    assign outFlat[k*DW +: DW] = outMem[k];
  end
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   hostAddr,
  input  logic         hostWrEn,
  input  logic [31:0]  hostWrData,
  input  logic         hostRdByte,
  output logic [31:0]  hostRdData,
  output logic         hostIrq,
  output logic         ctlDoorbell,
  output logic [7:0]   ctlCmdCode,
  output logic         ctlIoc,
  output logic [3:0]   ctlSubId,
  output logic [7:0]   ctlSize,
  output logic [127:0] ctlOutBuf,
  input  logic         ctlRspWe,
  input  logic [1:0]   ctlRspIdx,
  input  logic [31:0]  ctlRspData,
  input  logic         ctlDone,
  input  logic         ctlErr,
  input  logic [7:0]   ctlErrCode,
  input  logic [7:0]   ctlInitId
);
  mbxStrobe_t strb;
  logic busy, cmdWr, iocBit;

  mbx_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .iocBit(iocBit), .ctlDone(ctlDone),
    .strb(strb), .busy(busy), .doorbell(ctlDoorbell), .hostIrq(hostIrq)
  );

  mbx_data #(.BUF_WORDS(4), .DW(32)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .hostAddr(hostAddr), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdByte(hostRdByte), .hostRdData(hostRdData),
    .cmdWr(cmdWr), .iocBit(iocBit),
    .cmdCode(ctlCmdCode), .cmdIoc(ctlIoc), .subId(ctlSubId), .paySize(ctlSize),
    .outFlat(ctlOutBuf),
    .rspWe(ctlRspWe), .rspIdx(ctlRspIdx), .rspData(ctlRspData),
    .doneErr(ctlErr), .doneCode(ctlErrCode), .doneInit(ctlInitId)
  );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       hostWrEn,
  input logic [7:0] hostAddr,
  input logic       busy,
  input logic       ctlDone,
  input logic       ctlDoorbell,
  input logic       hostIrq,
  input logic [7:0] ctlCmdCode
);
  logic cmdHit;
  assign cmdHit = hostWrEn && (hostAddr == 8'h00);

  AST_BELL_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    cmdHit && !busy |=> ctlDoorbell && busy);  // R2
  AST_BELL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ctlDoorbell |=> !ctlDoorbell);  // R2
  AST_NO_BELL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cmdHit && busy |=> !ctlDoorbell && $stable(ctlCmdCode));  // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctlDone && busy |=> !busy);  // R4
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> $past(ctlDone && busy));  // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |=> !hostIrq);  // R5
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ctlDone && !busy |=> !hostIrq);  // R9
endmodule

bind mbx_top mbx_checker i_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
  .busy(busy), .ctlDone(ctlDone), .ctlDoorbell(ctlDoorbell),
  .hostIrq(hostIrq), .ctlCmdCode(ctlCmdCode)
);

// File: tb/test_mbx_top.sv
`timescale 1ns/1ps
module test_mbx_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] hostAddr = '0;
  logic hostWrEn = 1'b0;
  logic [31:0] hostWrData = '0;
  logic hostRdByte = 1'b0;
  logic [31:0] hostRdData;
  logic hostIrq, ctlDoorbell, ctlIoc;
  logic [7:0] ctlCmdCode, ctlSize;
  logic [3:0] ctlSubId;
  logic [127:0] ctlOutBuf;
  logic ctlRspWe = 1'b0;
  logic [1:0] ctlRspIdx = '0;
  logic [31:0] ctlRspData = '0;
  logic ctlDone = 1'b0, ctlErr = 1'b0;
  logic [7:0] ctlErrCode = '0, ctlInitId = '0;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  mbx_top i_mbx_top (.*);

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0; hostAddr = 8'h04;
  endtask

  task automatic hostRead(logic [7:0] a, logic byteMode, output logic [31:0] d);
    hostAddr = a; hostRdByte = byteMode;
    #1 d = hostRdData;
    hostRdByte = 1'b0;
  endtask

  task automatic ctlFinish(logic e, logic [7:0] code, logic [7:0] init);
    @(negedge clk);
    ctlDone = 1'b1; ctlErr = e; ctlErrCode = code; ctlInitId = init;
    @(negedge clk);
    ctlDone = 1'b0; ctlErr = 1'b0; ctlErrCode = '0; ctlInitId = '0;
  endtask

  task automatic loadRsp(logic [1:0] idx, logic [31:0] d);
    @(negedge clk);
    ctlRspWe = 1'b1; ctlRspIdx = idx; ctlRspData = d;
    @(negedge clk);
    ctlRspWe = 1'b0;
  endtask

  task automatic finishRun;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    finishRun();
  end

  initial begin
    logic [31:0] rd, cmdWord, expStat;
    logic [31:0] words [4];
    logic [7:0] code;
    logic [3:0] sub;
    logic [7:0] size;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    hostRead(8'h04, 1'b0, rd);
    chk("R1 status", rd, 0);
    chk("R1 bell", ctlDoorbell, 0);
    chk("R1 irq", hostIrq, 0);

    // Done while idle after reset
    ctlFinish(1'b1, 8'h55, 8'h66);
    chk("R9 irq idle", hostIrq, 0);
    hostRead(8'h04, 1'b0, rd);
    chk("R9 status idle", rd, 0);

    for (int step = 0; step < 16; step++) begin
      logic ioc, e;
      ioc  = step[0];
      e    = step[1];
      code = 8'(8'h11 * step + 3);
      sub  = 4'(step + 5);
      size = 8'(4 * (step % 5));
      for (int k = 0; k < 4; k++) begin
        words[k] = 32'hA0000000 ^ (step << 8) ^ (k * 32'h01010101);
        hostWrite(8'(8'h80 + 4 * k), words[k]);
      end
      for (int k = 0; k < 4; k++)
        chk("R7 outbuf", ctlOutBuf[32*k +: 32], words[k]);
      hostRead(8'h80, 1'b0, rd);
      chk("R10 outbuf reads zero", rd, 0);
      hostRead(8'h00, 1'b0, rd);
      chk("R10 cmd reads zero", rd, 0);
      hostRead(8'h40, 1'b0, rd);
      chk("R10 unmapped reads zero", rd, 0);

      cmdWord = {8'hEE, size, sub, 3'b111, ioc, code};
      hostWrite(8'h00, cmdWord);
      chk("R2 bell", ctlDoorbell, 1);
      chk("R2 code", ctlCmdCode, code);
      chk("R2 ioc", ctlIoc, ioc);
      chk("R2 sub", ctlSubId, sub);
      chk("R2 size", ctlSize, size);
      hostRead(8'h04, 1'b0, rd);
      chk("R2 busy", rd[0], 1);
      @(negedge clk);
      chk("R2 bell one cycle", ctlDoorbell, 0);

      // second command while busy
      hostWrite(8'h00, ~cmdWord);
      chk("R3 no bell", ctlDoorbell, 0);
      chk("R3 code kept", ctlCmdCode, code);
      chk("R3 ioc kept", ctlIoc, ioc);
      chk("R3 sub kept", ctlSubId, sub);
      chk("R3 size kept", ctlSize, size);

      for (int k = 0; k < 4; k++)
        loadRsp(2'(k), 32'h5A000000 + (step << 12) + (k << 4) + 32'h00030201);

      ctlFinish(e, 8'(code ^ 8'hC3), 8'(step + 8'h40));
      chk(ioc ? "R5 irq" : "R6 no irq", hostIrq, ioc);
      @(negedge clk);
      chk("R5 irq one cycle", hostIrq, 0);
      expStat = {8'h00, 8'(code ^ 8'hC3), 8'(step + 8'h40), sub, 2'b00, e, 1'b0};
      hostRead(8'h04, 1'b0, rd);
      chk("R4 status", rd, expStat);

      ctlFinish(~e, 8'hFF, 8'hFF);
      chk("R9 irq", hostIrq, 0);
      hostRead(8'h04, 1'b0, rd);
      chk("R9 status kept", rd, expStat);

      for (int k = 0; k < 4; k++) begin
        logic [31:0] w;
        w = 32'h5A000000 + (step << 12) + (k << 4) + 32'h00030201;
        hostRead(8'(8'h90 + 4 * k), 1'b0, rd);
        chk("R8 word", rd, w);
        for (int b = 0; b < 4; b++) begin
          hostRead(8'(8'h90 + 4 * k + b), 1'b1, rd);
          chk("R8 byte", rd, {24'h0, w[8*b +: 8]});
        end
      end
    end
    finishRun();
  end
endmodule